// File: doc/BRIEF.md
# Quad-pumped bus data transmitter

This block drives the data side of a shared 64-bit bus that moves four data sub-phases in every common clock. Each transfer clock it takes 256 bits of payload and splits them into four 64-bit sub-phases. Sub-phase p carries payload bits 64p+63 down to 64p. The sub-phase index stands in for the strobe edges, which are not modelled here. Strobe generation, pad timing and winning bus ownership are handled outside the block.

Inside each sub-phase the 64 bits form four 16-bit groups. A group whose logical content has more than eight ones is sent inverted, and a per-group inversion flag is raised. Each group also gets an even parity bit, computed over the 16 bits as they are driven. A transfer of N clocks begins with a one-clock start pulse that carries N. The stall input inserts idle clocks. The block raises a data-ready flag in every clock that carries data. For transfers longer than one clock it also holds a busy flag for the whole transfer.

Top module: `qptx_top`

## Requirements
- R1: When `rdyOut` is high, 16-bit slot i of `busOut` (bits 16i+15..16i, where i = 4·subphase + group) carries payload bits 16i+15..16i from the clock that produced it, inverted exactly when `dbiOut[i]` is set.
- R2: `dbiOut[i]` is set exactly when payload slot i holds more than 8 ones; a slot with 8 or fewer ones is sent as is.
- R3: No driven 16-bit slot ever carries more than 8 ones, and a slot with its flag set carries fewer than 8.
- R4: `parOut[i]` makes the driven 16 bits of slot i plus the parity bit even; `dbiOut[i]` is not covered.
- R5: A start pulse with nonzero `lenIn` = N, sampled while the block is idle, yields exactly N clocks with `rdyOut` high. Without stalls, the first of these is the second clock after the start clock.
- R6: A clock with `stallIn` high during a transfer consumes no payload and gives `rdyOut` low with bus, flags and parity zero in the next clock. The transfer then resumes.
- R7: For N > 1, `busyOut` is high from the first data clock through the last one, including stall gaps, and falls in the clock after the last `rdyOut`. For N = 1 it stays low.
- R8: A start pulse during a transfer, or one with `lenIn` = 0, is ignored.
- R9: While `rstN` is low, and in the first clock after it is released, all outputs are zero.
- R10: In every clock with `rdyOut` low, `busOut`, `dbiOut` and `parOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | One-clock request to begin a transfer |
| lenIn | input | 4 | Transfer length in clocks, sampled with startIn |
| stallIn | input | 1 | Inserts an idle clock during a transfer |
| payloadIn | input | 256 | Payload for the current transfer clock, sub-phase 0 in the low bits |
| busOut | output | 256 | Four encoded 64-bit sub-phases |
| dbiOut | output | 16 | Inversion flag per 16-bit slot |
| parOut | output | 16 | Even parity per 16-bit slot |
| rdyOut | output | 1 | Data valid in this clock |
| busyOut | output | 1 | Bus held for a multi-clock transfer |

## Verification
Two events can land on the same clock. A new start pulse can arrive in the clock where the previous burst's last `rdyOut` and still-high `busyOut` are on the pins. Separately, a stall can arrive next to the final beat. The bench chains bursts so that the next start falls in that last-data clock. For each chained start it expects `busyOut` to drop for exactly one clock, the new data to start two clocks after the start, and no payload item to be lost or duplicated in the scoreboard. Stall patterns placed near the end of a burst confirm that the last beat is delayed and not dropped, and that busy still falls only after it.

// File: rtl/qptx_pkg.sv
`timescale 1ns/1ps
package qptx_pkg;
  // Strobes sent from control to datapath
  typedef struct packed {
    logic load;   // capture and encode payload this clock
  } qptxStrobe_t;
endpackage

// File: rtl/qptx_grp_enc.sv
`timescale 1ns/1ps
module qptx_grp_enc #(
  parameter int GRP_W = 16
) (
  input  logic [GRP_W-1:0] dIn,
  output logic [GRP_W-1:0] dOut,
  output logic             invOut,
  output logic             parOut
);
  localparam int CNT_W = $clog2(GRP_W + 1);
  localparam int HALF  = GRP_W / 2;

  logic [CNT_W-1:0] onesCnt;

  always_comb begin
    onesCnt = CNT_W'($countones(dIn));
    invOut  = (onesCnt > CNT_W'(HALF));
    dOut    = invOut ? ~dIn : dIn;
    parOut  = ^dOut;
  end
endmodule

// File: rtl/qptx_datapath.sv
`timescale 1ns/1ps
module qptx_datapath
  import qptx_pkg::*;
#(
  parameter int BUS_W  = 64,
  parameter int GRP_W  = 16,
  parameter int PHASES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  qptxStrobe_t               strobe,
  input  logic [PHASES*BUS_W-1:0]   payloadIn,
  output logic [PHASES*BUS_W-1:0]   busOut,
  output logic [PHASES*BUS_W/GRP_W-1:0] dbiOut,
  output logic [PHASES*BUS_W/GRP_W-1:0] parOut
);
  localparam int NGRP  = BUS_W / GRP_W;
  localparam int NSLOT = PHASES * NGRP;

  logic [PHASES*BUS_W-1:0] encBus;
  logic [NSLOT-1:0]        encInv;
  logic [NSLOT-1:0]        encPar;

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam int SLOT = p * NGRP + g;
      qptx_grp_enc #(.GRP_W(GRP_W)) enc_i (
        .dIn   (payloadIn[SLOT*GRP_W +: GRP_W]),
        .dOut  (encBus[SLOT*GRP_W +: GRP_W]),
        .invOut(encInv[SLOT]),
        .parOut(encPar[SLOT])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOut <= '0;
      dbiOut <= '0;
      parOut <= '0;
    end else if (strobe.load) begin
      busOut <= encBus;
      dbiOut <= encInv;
      parOut <= encPar;
    end else begin
      busOut <= '0;
      dbiOut <= '0;
      parOut <= '0;
    end
  end
endmodule

// File: rtl/qptx_ctrl.sv
`timescale 1ns/1ps
module qptx_ctrl
  import qptx_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [LEN_W-1:0] lenIn,
  input  logic             stallIn,
  output qptxStrobe_t      strobe,
  output logic             rdyOut,
  output logic             busyOut
);
  logic             active;
  logic             multi;
  logic [LEN_W-1:0] remain;
  logic             fire;

  assign fire        = active && !stallIn;
  assign strobe.load = fire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      multi   <= 1'b0;
      remain  <= '0;
      rdyOut  <= 1'b0;
      busyOut <= 1'b0;
    end else begin
      if (!active) begin
        if (startIn && (lenIn != '0)) begin
          active <= 1'b1;
          remain <= lenIn;
          multi  <= (lenIn > LEN_W'(1));
        end
      end else if (!stallIn) begin
        remain <= remain - LEN_W'(1);
        if (remain == LEN_W'(1)) active <= 1'b0;
      end
      rdyOut  <= fire;
      busyOut <= active && multi;
    end
  end
endmodule

// File: rtl/qptx_top.sv
`timescale 1ns/1ps
module qptx_top
  import qptx_pkg::*;
#(
  parameter int BUS_W  = 64,
  parameter int GRP_W  = 16,
  parameter int PHASES = 4,
  parameter int LEN_W  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startIn,
  input  logic [LEN_W-1:0]              lenIn,
  input  logic                          stallIn,
  input  logic [PHASES*BUS_W-1:0]       payloadIn,
  output logic [PHASES*BUS_W-1:0]       busOut,
  output logic [PHASES*BUS_W/GRP_W-1:0] dbiOut,
  output logic [PHASES*BUS_W/GRP_W-1:0] parOut,
  output logic                          rdyOut,
  output logic                          busyOut
);
  qptxStrobe_t strobe;

  qptx_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lenIn(lenIn),
    .stallIn(stallIn), .strobe(strobe), .rdyOut(rdyOut), .busyOut(busyOut)
  );

  qptx_datapath #(.BUS_W(BUS_W), .GRP_W(GRP_W), .PHASES(PHASES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .payloadIn(payloadIn),
    .busOut(busOut), .dbiOut(dbiOut), .parOut(parOut)
  );
endmodule

// File: rtl/qptx_checker.sv
`timescale 1ns/1ps
module qptx_checker #(
  parameter int BUS_W  = 64,
  parameter int GRP_W  = 16,
  parameter int PHASES = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [PHASES*BUS_W-1:0]       busOut,
  input logic [PHASES*BUS_W/GRP_W-1:0] dbiOut,
  input logic [PHASES*BUS_W/GRP_W-1:0] parOut,
  input logic                          rdyOut,
  input logic                          busyOut
);
  localparam int NSLOT = PHASES * BUS_W / GRP_W;
  localparam int HALF  = GRP_W / 2;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assert_grp_weight_R3: assert property (@(posedge clk) disable iff (!rstN)
      rdyOut |-> ($countones(busOut[i*GRP_W +: GRP_W]) <= HALF));
    assert_flag_weight_R3: assert property (@(posedge clk) disable iff (!rstN)
      dbiOut[i] |-> ($countones(busOut[i*GRP_W +: GRP_W]) < HALF));
    assert_even_parity_R4: assert property (@(posedge clk) disable iff (!rstN)
      rdyOut |-> (^{busOut[i*GRP_W +: GRP_W], parOut[i]} == 1'b0));
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdyOut |-> (busOut == '0 && dbiOut == '0 && parOut == '0));

  assert_busy_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyOut) |-> $past(rdyOut));

  assert_reset_clear_R9: assert property (@(posedge clk)
    !rstN |=> (!rdyOut && !busyOut && busOut == '0));
endmodule

bind qptx_top qptx_checker #(.BUS_W(BUS_W), .GRP_W(GRP_W), .PHASES(PHASES)) chk_i (
  .clk(clk), .rstN(rstN), .busOut(busOut), .dbiOut(dbiOut),
  .parOut(parOut), .rdyOut(rdyOut), .busyOut(busyOut)
);

// File: tb/qptx_top_tb_top.sv
`timescale 1ns/1ps
module qptx_top_tb_top;
  localparam int PW = 256;
  localparam int NS = 16;
  localparam logic [15:0] PATS [4] = '{16'hFFFF, 16'h00FF, 16'h01FF, 16'h0000};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [3:0] lenIn = '0;
  logic stallIn = 1'b0;
  logic [PW-1:0] payloadIn = '0;
  logic [PW-1:0] busOut;
  logic [NS-1:0] dbiOut, parOut;
  logic rdyOut, busyOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [PW-1:0] b; logic [NS-1:0] d; logic [NS-1:0] p; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  qptx_top dut_i (
    .clk(clk), .rstN(rstN), .startIn(startIn), .lenIn(lenIn), .stallIn(stallIn),
    .payloadIn(payloadIn), .busOut(busOut), .dbiOut(dbiOut), .parOut(parOut),
    .rdyOut(rdyOut), .busyOut(busyOut)
  );

  task automatic chk(input bit ok, input string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic exp_t encode(input logic [PW-1:0] pl);
    exp_t e;
    for (int i = 0; i < NS; i++) begin
      logic [15:0] g;
      logic inv;
      g = pl[i*16 +: 16];
      inv = ($countones(g) > 8);
      e.b[i*16 +: 16] = inv ? ~g : g;
      e.d[i] = inv;
      e.p[i] = ^(inv ? ~g : g);
    end
    return e;
  endfunction

  function automatic logic [PW-1:0] mkPayload(input bit directed, input int k);
    logic [PW-1:0] v;
    for (int i = 0; i < NS; i++)
      v[i*16 +: 16] = directed ? PATS[(i + k) % 4] : 16'($urandom);
    return v;
  endfunction

  // Monitor: scoreboard comparison of each data clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rdyOut) begin
        if (q.size() == 0) begin
          chk(1'b0, "R8 unexpected data clock: act rdy=1 exp rdy=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(busOut == e.b, $sformatf("R1 bus act=%h exp=%h", busOut, e.b));
          chk(dbiOut == e.d, $sformatf("R2 dbi act=%h exp=%h", dbiOut, e.d));
          chk(parOut == e.p, $sformatf("R4 parity act=%h exp=%h", parOut, e.p));
        end
      end else begin
        chk(busOut == '0 && dbiOut == '0 && parOut == '0,
            $sformatf("R10 idle lines act bus=%h dbi=%h par=%h exp zero", busOut, dbiOut, parOut));
      end
    end
  end

  // Driver: called just after a falling edge
  task automatic burst(input int n, input logic [15:0] stallPat, input bit directed,
                       input bit chain, input bit junk);
    int fired = 0;
    int c = 0;
    startIn = 1'b1;
    lenIn = 4'(n);
    payloadIn = mkPayload(directed, 0);
    @(negedge clk);
    startIn = 1'b0;
    chk(busyOut == 1'b0, $sformatf("R7 busy in start clock act=%0b exp=0", busyOut));
    while (fired < n) begin
      bit st;
      st = (c < 16) ? stallPat[c] : 1'b0;
      stallIn = st;
      payloadIn = mkPayload(directed, c + 1);
      if (!st) begin
        q.push_back(encode(payloadIn));
        fired++;
      end
      if (junk && c == 1) begin startIn = 1'b1; lenIn = 4'd7; end
      else if (junk && c == 2) startIn = 1'b0;
      @(negedge clk);
      chk(rdyOut == !st, $sformatf("R5/R6 rdy after clock %0d act=%0b exp=%0b", c, rdyOut, !st));
      chk(busyOut == (n > 1), $sformatf("R7 busy during burst act=%0b exp=%0b", busyOut, n > 1));
      c++;
    end
    stallIn = 1'b0;
    startIn = 1'b0;
    if (!chain) begin
      @(negedge clk);
      chk(busyOut == 1'b0 && rdyOut == 1'b0,
          $sformatf("R7 release act busy=%0b rdy=%0b exp 0 0", busyOut, rdyOut));
      if (junk) begin
        repeat (4) begin
          @(negedge clk);
          chk(rdyOut == 1'b0, $sformatf("R8 start during burst ignored act rdy=%0b exp=0", rdyOut));
        end
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busOut == '0 && rdyOut == 1'b0 && busyOut == 1'b0,
        $sformatf("R9 in reset act rdy=%0b busy=%0b exp 0 0", rdyOut, busyOut));
    rstN = 1'b1;
    @(negedge clk);
    chk(busOut == '0 && dbiOut == '0 && rdyOut == 1'b0 && busyOut == 1'b0,
        $sformatf("R9 after reset act rdy=%0b busy=%0b exp 0 0", rdyOut, busyOut));

    burst(1, 16'h0000, 1'b1, 1'b0, 1'b0);   // single clock: no busy (R7)
    burst(4, 16'h0000, 1'b1, 1'b0, 1'b0);   // directed weights 16/8/9/0 (R2, R3)
    burst(5, 16'h0026, 1'b0, 1'b0, 1'b1);   // stalls plus ignored start (R6, R8)
    burst(6, 16'h0301, 1'b0, 1'b0, 1'b0);
    burst(3, 16'h0004, 1'b0, 1'b1, 1'b0);   // chained start in last data clock
    burst(2, 16'h0000, 1'b0, 1'b1, 1'b0);
    burst(1, 16'h0000, 1'b1, 1'b0, 1'b0);

    // zero length start is ignored (R8)
    startIn = 1'b1; lenIn = 4'd0;
    @(negedge clk);
    startIn = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(rdyOut == 1'b0 && busyOut == 1'b0,
          $sformatf("R8 zero length act rdy=%0b busy=%0b exp 0 0", rdyOut, busyOut));
    end

    for (int k = 0; k < 12; k++)
      burst(1 + (k % 6), 16'($urandom) & 16'h0A0A, 1'b0, k[0], 1'b0);
    burst(15, 16'h8001, 1'b0, 1'b0, 1'b0);

    repeat (3) @(negedge clk);
    chk(q.size() == 0, $sformatf("R5 pending items act=%0d exp=0", q.size()));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule